// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead-Time Insertion

This block controls the four switches of one full bridge. The bridge has two legs, and each leg has a high-side switch and a low-side switch. Three asynchronous controls drive it: a bridge enable and one command per leg. Each control first passes through a two-flop synchronizer. The block then decodes the synchronized values into the switch each leg should conduct and registers four active-high gate-enable outputs.

While the bridge is disabled, every switch is off and both bridge outputs float. While it is enabled, a high command connects that leg to the supply through its high-side switch, and a low command connects it to ground through its low-side switch. Equal commands therefore brake the load, either to the supply rail or to the ground rail.

When a leg moves from one switch to the other, the conducting switch turns off at once. Both switches then stay off for a programmable number of clock cycles before the other switch turns on. Turn-off is fast and turn-on is delayed. A design with two bridges uses two instances. A separate fault block pulls the enable low to protect the bridge.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, all four gate outputs are 0.
- R2: When `bridge_en` is low, all four gates go to 0 on the third rising clock edge after the change, whatever the commands are. No dead-time wait applies, and the gates stay 0 while the enable stays low.
- R3: With the enable high, each leg follows its own command independently. Command 1 selects the high-side gate (`*_hi` = 1, `*_lo` = 0). Command 0 selects the low-side gate (`*_hi` = 0, `*_lo` = 1).
- R4: With the enable high, equal commands brake the load. `cmd_a` = `cmd_b` = 0 turns on both low-side gates. `cmd_a` = `cmd_b` = 1 turns on both high-side gates.
- R5: In no cycle are the high-side and low-side gates of the same leg both 1.
- R6: When a leg's command flips, the gate that was on goes to 0 on the third rising edge after the input change.
- R7: After such a turn-off, the other gate of that leg turns on exactly `DEAD_CYCLES`+1 cycles later. A leg never turns a gate on after fewer than `DEAD_CYCLES` consecutive cycles with both of its gates off.
- R8: When the enable rises with the gates off, each leg's selected gate turns on at rising edge 3+`DEAD_CYCLES` after the enable change, and not earlier.
- R9: A leg whose selected switch does not change keeps its gate on without interruption, even while the other leg or the enable history changes.
- R10: If a leg's command reverses while the leg is in its dead interval, the interval is not restarted. The switch selected by the newest command turns on when the running interval ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bridge_en | input | 1 | Asynchronous bridge enable, active high |
| cmd_a | input | 1 | Asynchronous command for leg A (1 = supply, 0 = ground) |
| cmd_b | input | 1 | Asynchronous command for leg B (1 = supply, 0 = ground) |
| gate_a_hi | output | 1 | Leg A high-side gate enable |
| gate_a_lo | output | 1 | Leg A low-side gate enable |
| gate_b_hi | output | 1 | Leg B high-side gate enable |
| gate_b_lo | output | 1 | Leg B low-side gate enable |

## Verification
The bench starts from each of the eight settled combinations of enable and two commands and steps to each of the eight combinations again. That gives 64 transitions, which cover side swaps, brakes, re-enables, disables and legs that do not change. Samples taken one edge before the turn-off point, at it, one edge before turn-on and at turn-on tell apart a leg that is swapping (R6, R7), a leg that is starting from disable (R8) and a leg that must hold (R9). A separate case reverses a leg's command in the middle of its dead interval, which shows whether the interval restarts.

// File: rtl/hbg_pkg.sv
// Shared types for the H-bridge gate sequencer.
// Assumes: a leg conducts through at most one of its two switches.
package hbg_pkg;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'b00,
        SIDE_LOW  = 2'b01,
        SIDE_HIGH = 2'b10
    } side_t;

    // Map enable and leg command to the wanted conducting switch.
    function automatic side_t side_decode(input logic en, input logic cmd);
        if (!en)
            return SIDE_NONE;
        return cmd ? SIDE_HIGH : SIDE_LOW;
    endfunction

endpackage

// File: rtl/hbg_sync.sv
// Multi-bit flop-chain synchronizer. Each bit is synchronized independently.
// Assumes: bits are unrelated levels, so skew between bits is harmless.
module hbg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the input one stage further through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= async_in;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/hbg_leg.sv
// One bridge leg: picks the high or low switch from the synchronized enable
// and command. Turns the conducting switch off at once, and waits a dead
// interval with both switches off before turning any switch on.
// Assumes: en_s and cmd_s are synchronous to clk; DEAD_CYCLES >= 1.
module hbg_leg
    import hbg_pkg::*;
#(
    parameter int DEAD_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic cmd_s,
    output logic gate_hi,
    output logic gate_lo
);

    localparam int CW = $clog2(DEAD_CYCLES + 1);
    localparam logic [CW-1:0] DEAD_LOAD = CW'(DEAD_CYCLES);

    side_t         want;
    logic [CW-1:0] dead_cnt;
    logic          wrong_side;

    // Wanted switch for this leg this cycle.
    always_comb want = side_decode(en_s, cmd_s);

    // A switch is on but the command now asks for the other one.
    always_comb wrong_side = (gate_hi && want == SIDE_LOW) ||
                             (gate_lo && want == SIDE_HIGH);

    // Gate state and dead-interval countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi  <= 1'b0;
            gate_lo  <= 1'b0;
            dead_cnt <= DEAD_LOAD;
        end else if (want == SIDE_NONE) begin
            gate_hi  <= 1'b0;
            gate_lo  <= 1'b0;
            dead_cnt <= DEAD_LOAD;
        end else if (gate_hi || gate_lo) begin
            if (wrong_side) begin
                gate_hi  <= 1'b0;
                gate_lo  <= 1'b0;
                dead_cnt <= DEAD_LOAD;
            end
        end else if (dead_cnt != '0) begin
            dead_cnt <= dead_cnt - 1'b1;
        end else begin
            gate_hi <= (want == SIDE_HIGH);
            gate_lo <= (want == SIDE_LOW);
        end
    end

    // Count of consecutive cycles with both gates off, saturating (check only).
    logic [CW-1:0] off_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_run <= '0;
        else if (gate_hi || gate_lo)
            off_run <= '0;
        else if (off_run != DEAD_LOAD)
            off_run <= off_run + 1'b1;
    end

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo)); // R5
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (!gate_hi && !gate_lo)); // R2
    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) || $rose(gate_lo)) |-> (off_run >= DEAD_LOAD)); // R7
    AST_HOLD_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && gate_hi && cmd_s) |=> gate_hi); // R9

endmodule

// File: rtl/hbridge_gate_ctrl.sv
// Full-bridge gate sequencer: synchronizes enable and both leg commands,
// then drives one dead-time leg controller per leg.
// Assumes: inputs are asynchronous levels; outputs are active-high gates.
module hbridge_gate_ctrl #(
    parameter int DEAD_CYCLES = 125,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bridge_en,
    input  logic cmd_a,
    input  logic cmd_b,
    output logic gate_a_hi,
    output logic gate_a_lo,
    output logic gate_b_hi,
    output logic gate_b_lo
);

    localparam int LEGS = 2;
    localparam int SW   = LEGS + 1;

    logic [SW-1:0]   raw_in;
    logic [SW-1:0]   sync_in;
    logic [LEGS-1:0] leg_hi;
    logic [LEGS-1:0] leg_lo;

    assign raw_in = {bridge_en, cmd_b, cmd_a};

    hbg_sync #(
        .WIDTH  (SW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (sync_in)
    );

    genvar l;
    generate
        for (l = 0; l < LEGS; l++) begin : g_leg
            hbg_leg #(
                .DEAD_CYCLES (DEAD_CYCLES)
            ) u_leg (
                .clk     (clk),
                .rst_n   (rst_n),
                .en_s    (sync_in[SW-1]),
                .cmd_s   (sync_in[l]),
                .gate_hi (leg_hi[l]),
                .gate_lo (leg_lo[l])
            );
        end
    endgenerate

    assign gate_a_hi = leg_hi[0];
    assign gate_a_lo = leg_lo[0];
    assign gate_b_hi = leg_hi[1];
    assign gate_b_lo = leg_lo[1];

endmodule

// File: tb/hbridge_gate_ctrl_test.sv
module hbridge_gate_ctrl_test;

    localparam int DEAD = 4;   // small dead interval for the sweep
    localparam int LAT  = 3;   // two sync flops plus the gate register

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bridge_en = 1'b0;
    logic cmd_a = 1'b0;
    logic cmd_b = 1'b0;
    logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hbridge_gate_ctrl #(.DEAD_CYCLES(DEAD), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en),
        .cmd_a(cmd_a), .cmd_b(cmd_b),
        .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo),
        .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo)
    );

    // Leg code {hi,lo}: 10 = supply, 01 = ground, 00 = off.
    function automatic logic [1:0] side(input logic en, input logic c);
        return !en ? 2'b00 : (c ? 2'b10 : 2'b01);
    endfunction

    // Expected leg code at a checkpoint (edges after the input change).
    function automatic logic [1:0] leg_exp(input logic [1:0] o, input logic [1:0] n, input int e);
        if (o == n) return o;
        if (o == 2'b00) return (e >= LAT + DEAD) ? n : 2'b00;
        if (e < LAT) return o;
        if (e <= LAT + DEAD) return 2'b00;
        return n;
    endfunction

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: gates=%b expected=%b", tag, act, exp);
        end
        n_checks++;
        if ((gate_a_hi && gate_a_lo) || (gate_b_hi && gate_b_lo)) begin
            n_fail++;
            $display("FAIL R5: gates=%b expected no leg with both on", act);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        bridge_en = 1'b1; cmd_a = 1'b1; cmd_b = 1'b0;
        adv(5);
        chk("R1 in reset", 4'b0000);
        rst_n = 1'b1;
        adv(1);
        chk("R1 after release", 4'b0000);

        // Sweep all 64 settled-state to settled-state transitions.
        for (int f = 0; f < 8; f++) begin
            for (int t = 0; t < 8; t++) begin
                logic [1:0] oa, ob, na, nb;
                string st, tg;
                {bridge_en, cmd_b, cmd_a} = 3'(f);
                adv(LAT + DEAD + 2);
                oa = side(f[2], f[0]); ob = side(f[2], f[1]);
                st = !f[2] ? "R2 settled off" : (f[0] == f[1] ? "R4 settled brake" : "R3 settled");
                chk(st, {oa, ob});
                {bridge_en, cmd_b, cmd_a} = 3'(t);
                na = side(t[2], t[0]); nb = side(t[2], t[1]);
                tg = !t[2] ? "R2" : (!f[2] ? "R8" : ((oa == na && ob == nb) ? "R9" : "R6/R7"));
                adv(LAT - 1);
                chk({tg, " before turn-off"}, {leg_exp(oa, na, LAT-1), leg_exp(ob, nb, LAT-1)});
                adv(1);
                chk({tg, " turn-off edge"}, {leg_exp(oa, na, LAT), leg_exp(ob, nb, LAT)});
                adv(DEAD - 1);
                chk({tg, " before re-enable on"}, {leg_exp(oa, na, LAT+DEAD-1), leg_exp(ob, nb, LAT+DEAD-1)});
                adv(1);
                chk({tg, " re-enable on / R7 gap"}, {leg_exp(oa, na, LAT+DEAD), leg_exp(ob, nb, LAT+DEAD)});
                adv(1);
                chk({tg, " R7 swap on"}, {leg_exp(oa, na, LAT+DEAD+1), leg_exp(ob, nb, LAT+DEAD+1)});
            end
        end

        // R10: reversal inside the dead interval keeps the running count.
        bridge_en = 1'b1; cmd_a = 1'b1; cmd_b = 1'b0;
        adv(LAT + DEAD + 2);
        chk("R10 setup", 4'b1001);
        cmd_a = 1'b0;
        adv(LAT);
        chk("R10 off after flip", 4'b0001);
        adv(1);
        cmd_a = 1'b1;
        adv(3);
        chk("R10 still in gap", 4'b0001);
        adv(1);
        chk("R10 high side back at end of gap", 4'b1001);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule